// File: doc/BRIEF.md
# Paged Frame Memory Window Decoder

This block lets a host with a 1 MB address space reach a 512 x 512 frame store of 8-bit pixels through a 64 KB window. The window shows one quarter of the frame at a time. Which quarter it shows is set by a two-bit page input. The window's base address comes from two inputs: a board-level strap and a software select bit. An enable bit attaches the store to the host bus only while software is actually moving pixels. The store is not attached at any other time.

A rotate bit changes how the window is ordered. With rotate clear, consecutive host bytes walk along a horizontal line of the image. With rotate set, they walk down a vertical line. The block converts each accepted host access into a registered frame store address in row-major order, plus a write strobe or a read enable. On reads it drives the returned pixel onto the host data path for exactly one cycle and raises a drive-enable alongside it. Video scan-out is outside the block and does not depend on the enable bit.

Top module: `frame_window`

## Requirements
- R1: During and directly after reset, store_we, store_re and host_oe are 0, host_rdata is 0 and store_addr is 0.
- R2: The window base is chosen by the index {base_sel, strap_up}: 00 gives 0xA0000, 01 gives 0xB0000, 10 gives 0xD0000 and 11 gives 0xE0000. An access hits when host_addr[19:16] equals the upper nibble of the chosen base.
- R3: The linear frame offset of a hit is page_sel * 65536 + host_addr[15:0]. page_sel supplies offset bits 17:16.
- R4: With rotate at 0, store_addr equals the linear offset. store_addr[17:9] is the line y and store_addr[8:0] is the pixel x, so offset y*512 + x reaches pixel (x, y).
- R5: With rotate at 1, the linear offset is read as x*512 + y, and store_addr is {offset[8:0], offset[17:9]}. For example, page 1 with window offset 0x0203 gives store_addr 0x681.
- R6: A write strobe that hits while ram_en is 1 raises store_we on the next cycle only. In that cycle store_addr is the mapped address and store_wdata is the strobed data.
- R7: A read strobe that hits while ram_en is 1 raises store_re and host_oe on the next cycle only, with host_rdata equal to store_rdata. At all other times host_oe is 0 and host_rdata is 0.
- R8: While ram_en is 0, no strobe causes store_we, store_re or host_oe.
- R9: A strobe whose address is outside the selected window is ignored even with ram_en at 1, and store_addr keeps its previous value.
- R10: When host_rd and host_wr are both 1 in one cycle, only the write is carried out and host_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 20 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| strap_up | input | 1 | Board strap position (1 = up) |
| base_sel | input | 1 | Software base-select bit |
| ram_en | input | 1 | Attach store to host bus |
| rotate | input | 1 | Column-major window ordering |
| page_sel | input | 2 | Frame quarter shown in the window |
| store_addr | output | 18 | Frame store address, row-major |
| store_we | output | 1 | Frame store write strobe |
| store_re | output | 1 | Frame store read enable |
| store_wdata | output | 8 | Frame store write data |
| store_rdata | input | 8 | Frame store read data (combinational from store_addr) |
| host_oe | output | 1 | Host data bus drive enable |
| host_rdata | output | 8 | Read data towards host, 0 when not driven |

## Verification
The properties assume that every input is known after reset and that each input changes only between rising edges. Under that assumption, the value seen one edge earlier through $past is the value that caused the access. They also assume that the store returns read data combinationally from store_addr in the same cycle. The bench meets these assumptions in three ways. It drives every input at the falling edge and keeps each input at a defined level from time zero. It models the store as a fixed combinational function of store_addr, so that every read has a known expected pixel. Strobes are single-cycle pulses separated by idle cycles, so each registered response can be checked on its own.

// File: rtl/frame_window_pkg.sv
package frame_window_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } fw_acc_t;

    localparam logic [19:0] FW_BASE_LO_DN = 20'hA0000;
    localparam logic [19:0] FW_BASE_LO_UP = 20'hB0000;
    localparam logic [19:0] FW_BASE_HI_DN = 20'hD0000;
    localparam logic [19:0] FW_BASE_HI_UP = 20'hE0000;

endpackage

// File: rtl/fw_base_decode.sv
module fw_base_decode #(
    parameter int HOST_AW = 20,
    parameter int WIN_BITS = 16,
    parameter logic [HOST_AW-1:0] BASE_0 = 20'hA0000,
    parameter logic [HOST_AW-1:0] BASE_1 = 20'hB0000,
    parameter logic [HOST_AW-1:0] BASE_2 = 20'hD0000,
    parameter logic [HOST_AW-1:0] BASE_3 = 20'hE0000
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               strap_up,
    input  logic               base_sel,
    output logic               hit
);
    localparam int TOP_W = HOST_AW - WIN_BITS;
    localparam int NUM_BASES = 4;

    logic [TOP_W-1:0] base_top [NUM_BASES];
    logic [TOP_W-1:0] match_top;
    logic [1:0]       base_idx;

    assign base_top[0] = BASE_0[HOST_AW-1:WIN_BITS];
    assign base_top[1] = BASE_1[HOST_AW-1:WIN_BITS];
    assign base_top[2] = BASE_2[HOST_AW-1:WIN_BITS];
    assign base_top[3] = BASE_3[HOST_AW-1:WIN_BITS];

    always_comb begin
        base_idx  = {base_sel, strap_up};
        match_top = base_top[base_idx];
        hit       = (host_addr[HOST_AW-1:WIN_BITS] == match_top);
    end
endmodule

// File: rtl/fw_addr_map.sv
module fw_addr_map #(
    parameter int SIDE_BITS = 9,
    parameter int WIN_BITS = 16
) (
    input  logic [2*SIDE_BITS-WIN_BITS-1:0] page_sel,
    input  logic [WIN_BITS-1:0]             win_off,
    input  logic                            rotate,
    output logic [2*SIDE_BITS-1:0]          store_addr
);
    localparam int OFF_W = 2 * SIDE_BITS;

    logic [OFF_W-1:0] lin_off;
    logic [OFF_W-1:0] swapped;

    assign lin_off = {page_sel, win_off};

    // A column-major offset is {x, y}; the store wants {y, x}.
    for (genvar i = 0; i < SIDE_BITS; i++) begin : g_swap
        assign swapped[SIDE_BITS+i] = lin_off[i];
        assign swapped[i]           = lin_off[SIDE_BITS+i];
    end

    assign store_addr = rotate ? swapped : lin_off;
endmodule

// File: rtl/frame_window.sv
module frame_window
    import frame_window_pkg::*;
#(
    parameter int HOST_AW = 20,
    parameter int WIN_BITS = 16,
    parameter int SIDE_BITS = 9,
    parameter int PIX_W = 8,
    parameter logic [HOST_AW-1:0] BASE_0 = FW_BASE_LO_DN,
    parameter logic [HOST_AW-1:0] BASE_1 = FW_BASE_LO_UP,
    parameter logic [HOST_AW-1:0] BASE_2 = FW_BASE_HI_DN,
    parameter logic [HOST_AW-1:0] BASE_3 = FW_BASE_HI_UP,
    localparam int OFF_W = 2 * SIDE_BITS,
    localparam int PAGE_W = OFF_W - WIN_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [PIX_W-1:0]   host_wdata,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic               strap_up,
    input  logic               base_sel,
    input  logic               ram_en,
    input  logic               rotate,
    input  logic [PAGE_W-1:0]  page_sel,
    output logic [OFF_W-1:0]   store_addr,
    output logic               store_we,
    output logic               store_re,
    output logic [PIX_W-1:0]   store_wdata,
    input  logic [PIX_W-1:0]   store_rdata,
    output logic               host_oe,
    output logic [PIX_W-1:0]   host_rdata
);
    typedef struct packed {
        logic             we;
        logic             re;
        logic [OFF_W-1:0] addr;
        logic [PIX_W-1:0] wdata;
    } fw_state_t;

    fw_state_t state_d, state_q;
    fw_acc_t   acc_d;
    logic      hit_w;
    logic [OFF_W-1:0] mapped_w;

    fw_base_decode #(
        .HOST_AW(HOST_AW), .WIN_BITS(WIN_BITS),
        .BASE_0(BASE_0), .BASE_1(BASE_1), .BASE_2(BASE_2), .BASE_3(BASE_3)
    ) u_base (
        .host_addr(host_addr),
        .strap_up(strap_up),
        .base_sel(base_sel),
        .hit(hit_w)
    );

    fw_addr_map #(
        .SIDE_BITS(SIDE_BITS), .WIN_BITS(WIN_BITS)
    ) u_map (
        .page_sel(page_sel),
        .win_off(host_addr[WIN_BITS-1:0]),
        .rotate(rotate),
        .store_addr(mapped_w)
    );

    always_comb begin
        state_d = state_q;
        acc_d   = ACC_NONE;
        if (hit_w && ram_en) begin
            if (host_wr)      acc_d = ACC_WRITE;
            else if (host_rd) acc_d = ACC_READ;
        end
        state_d.we = (acc_d == ACC_WRITE);
        state_d.re = (acc_d == ACC_READ);
        if (acc_d != ACC_NONE) state_d.addr = mapped_w;
        if (acc_d == ACC_WRITE) state_d.wdata = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign store_addr  = state_q.addr;
    assign store_we    = state_q.we;
    assign store_re    = state_q.re;
    assign store_wdata = state_q.wdata;
    assign host_oe     = state_q.re;
    assign host_rdata  = state_q.re ? store_rdata : '0;
endmodule

// File: rtl/frame_window_chk.sv
module frame_window_chk #(
    parameter int HOST_AW = 20,
    parameter int WIN_BITS = 16,
    parameter int SIDE_BITS = 9,
    parameter int PIX_W = 8,
    parameter logic [HOST_AW-1:0] BASE_0 = 20'hA0000,
    parameter logic [HOST_AW-1:0] BASE_1 = 20'hB0000,
    parameter logic [HOST_AW-1:0] BASE_2 = 20'hD0000,
    parameter logic [HOST_AW-1:0] BASE_3 = 20'hE0000
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [HOST_AW-1:0]            host_addr,
    input logic                          host_rd,
    input logic                          host_wr,
    input logic                          strap_up,
    input logic                          base_sel,
    input logic                          ram_en,
    input logic                          rotate,
    input logic [2*SIDE_BITS-WIN_BITS-1:0] page_sel,
    input logic [2*SIDE_BITS-1:0]        store_addr,
    input logic                          store_we,
    input logic                          store_re,
    input logic                          host_oe,
    input logic [PIX_W-1:0]              host_rdata
);
    localparam int OFF_W = 2 * SIDE_BITS;
    localparam int TOP_W = HOST_AW - WIN_BITS;

    logic [TOP_W-1:0] exp_top;
    logic [OFF_W-1:0] lin_w;

    always_comb begin
        case ({base_sel, strap_up})
            2'b00:   exp_top = BASE_0[HOST_AW-1:WIN_BITS];
            2'b01:   exp_top = BASE_1[HOST_AW-1:WIN_BITS];
            2'b10:   exp_top = BASE_2[HOST_AW-1:WIN_BITS];
            default: exp_top = BASE_3[HOST_AW-1:WIN_BITS];
        endcase
        lin_w = {page_sel, host_addr[WIN_BITS-1:0]};
    end

    AST_WE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> $past(ram_en && host_wr)); // R8
    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        host_oe |-> $past(ram_en && host_rd && !host_wr)); // R10
    AST_OE_FOLLOWS_RE: assert property (@(posedge clk) disable iff (!rst_n)
        host_oe == store_re); // R7
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !host_oe |-> (host_rdata == '0)); // R7
    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> ($past(host_addr[HOST_AW-1:WIN_BITS]) == $past(exp_top))); // R9
    AST_ROW_MAJOR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (store_we || store_re) && !$past(rotate) |-> store_addr == $past(lin_w)); // R4
    AST_COL_MAJOR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (store_we || store_re) && $past(rotate) |->
            (store_addr[SIDE_BITS-1:0] == $past(lin_w[OFF_W-1:SIDE_BITS]))
            && (store_addr[OFF_W-1:SIDE_BITS] == $past(lin_w[SIDE_BITS-1:0]))); // R5
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !store_we && !store_re |-> $stable(store_addr)); // R9
endmodule

bind frame_window frame_window_chk #(
    .HOST_AW(HOST_AW), .WIN_BITS(WIN_BITS), .SIDE_BITS(SIDE_BITS), .PIX_W(PIX_W),
    .BASE_0(BASE_0), .BASE_1(BASE_1), .BASE_2(BASE_2), .BASE_3(BASE_3)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .strap_up(strap_up), .base_sel(base_sel), .ram_en(ram_en),
    .rotate(rotate), .page_sel(page_sel), .store_addr(store_addr),
    .store_we(store_we), .store_re(store_re), .host_oe(host_oe),
    .host_rdata(host_rdata)
);

// File: tb/frame_window_tb.sv
module frame_window_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic        strap_up = 1'b0;
    logic        base_sel = 1'b0;
    logic        ram_en = 1'b0;
    logic        rotate = 1'b0;
    logic [1:0]  page_sel = '0;
    logic [17:0] store_addr;
    logic        store_we;
    logic        store_re;
    logic [7:0]  store_wdata;
    logic [7:0]  store_rdata;
    logic        host_oe;
    logic [7:0]  host_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // store model: pixel value is a fixed function of its address
    assign store_rdata = store_addr[7:0] ^ {store_addr[17:12], 2'b01};

    frame_window u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .strap_up(strap_up),
        .base_sel(base_sel), .ram_en(ram_en), .rotate(rotate), .page_sel(page_sel),
        .store_addr(store_addr), .store_we(store_we), .store_re(store_re),
        .store_wdata(store_wdata), .store_rdata(store_rdata), .host_oe(host_oe),
        .host_rdata(host_rdata)
    );

    function automatic logic [17:0] exp_map(input logic [1:0] pg,
                                            input logic [15:0] off, input logic rot);
        logic [17:0] lin;
        lin = {pg, off};
        return rot ? {lin[8:0], lin[17:9]} : lin;
    endfunction

    function automatic logic [7:0] pix_of(input logic [17:0] a);
        return a[7:0] ^ {a[17:12], 2'b01};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic strobe(input logic [19:0] a, input logic [7:0] d,
                          input logic wr, input logic rd);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = wr; host_rd = rd;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [17:0] a, input logic [7:0] d);
        chk(req, "store_we", 32'(store_we), 32'd1);
        chk(req, "store_addr", 32'(store_addr), 32'(a));
        chk(req, "store_wdata", 32'(store_wdata), 32'(d));
        chk(req, "host_oe on write", 32'(host_oe), 32'd0);
        @(negedge clk);
        chk("R6", "store_we pulse ends", 32'(store_we), 32'd0);
    endtask

    task automatic expect_idle(input string req, input logic [17:0] held);
        chk(req, "store_we idle", 32'(store_we), 32'd0);
        chk(req, "host_oe idle", 32'(host_oe), 32'd0);
        chk(req, "host_rdata idle", 32'(host_rdata), 32'd0);
        chk(req, "store_addr held", 32'(store_addr), 32'(held));
    endtask

    task automatic t_reset;
        chk("R1", "store_we", 32'(store_we), 32'd0);
        chk("R1", "store_re", 32'(store_re), 32'd0);
        chk("R1", "host_oe", 32'(host_oe), 32'd0);
        chk("R1", "host_rdata", 32'(host_rdata), 32'd0);
        chk("R1", "store_addr", 32'(store_addr), 32'd0);
    endtask

    task automatic t_bases;
        logic [19:0] bases [4];
        bases[0] = 20'hA0000; bases[1] = 20'hB0000;
        bases[2] = 20'hD0000; bases[3] = 20'hE0000;
        ram_en = 1'b1; rotate = 1'b0; page_sel = 2'd0;
        for (int i = 0; i < 4; i++) begin
            {base_sel, strap_up} = 2'(i);
            strobe(bases[i] | 20'h01234, 8'(8'h40 + i), 1'b1, 1'b0);
            expect_write("R2", 18'h01234, 8'(8'h40 + i));
            strobe(bases[(i+1)%4] | 20'h00055, 8'hEE, 1'b1, 1'b0);
            expect_idle("R9", 18'h01234);
        end
    endtask

    task automatic t_pages;
        base_sel = 1'b1; strap_up = 1'b1; ram_en = 1'b1; rotate = 1'b0;
        for (int p = 0; p < 4; p++) begin
            page_sel = 2'(p);
            strobe(20'hEFFFF, 8'(p), 1'b1, 1'b0);
            expect_write("R3", {2'(p), 16'hFFFF}, 8'(p));
        end
        page_sel = 2'd2;
        strobe(20'hE0205, 8'h77, 1'b1, 1'b0);
        expect_write("R4", 18'h20205, 8'h77);
    endtask

    task automatic t_rotate;
        base_sel = 1'b1; strap_up = 1'b1; ram_en = 1'b1; rotate = 1'b1;
        page_sel = 2'd1;
        strobe(20'hE0203, 8'h5A, 1'b1, 1'b0);
        expect_write("R5", 18'h00681, 8'h5A);
        page_sel = 2'd3;
        strobe(20'hE9ABC, 8'hC3, 1'b1, 1'b0);
        expect_write("R5", exp_map(2'd3, 16'h9ABC, 1'b1), 8'hC3);
        page_sel = 2'd0;
        strobe(20'hE01FF, 8'h00, 1'b0, 1'b1);
        chk("R5", "rotated read addr", 32'(store_addr), 32'(exp_map(2'd0, 16'h01FF, 1'b1)));
        chk("R5", "rotated read data", 32'(host_rdata),
            32'(pix_of(exp_map(2'd0, 16'h01FF, 1'b1))));
        @(negedge clk);
    endtask

    task automatic t_read;
        base_sel = 1'b0; strap_up = 1'b1; ram_en = 1'b1; rotate = 1'b0;
        page_sel = 2'd3;
        strobe(20'hB4F21, 8'h00, 1'b0, 1'b1);
        chk("R7", "host_oe", 32'(host_oe), 32'd1);
        chk("R7", "store_re", 32'(store_re), 32'd1);
        chk("R7", "store_addr", 32'(store_addr), 32'h34F21);
        chk("R7", "host_rdata", 32'(host_rdata), 32'(pix_of(18'h34F21)));
        chk("R7", "no write on read", 32'(store_we), 32'd0);
        @(negedge clk);
        chk("R7", "host_oe drops", 32'(host_oe), 32'd0);
        chk("R7", "host_rdata released", 32'(host_rdata), 32'd0);
    endtask

    task automatic t_ram_off;
        logic [17:0] held;
        base_sel = 1'b0; strap_up = 1'b0; rotate = 1'b0; page_sel = 2'd1;
        ram_en = 1'b1;
        strobe(20'hA0010, 8'h11, 1'b1, 1'b0);
        expect_write("R6", 18'h10010, 8'h11);
        held = 18'h10010;
        ram_en = 1'b0;
        strobe(20'hA0999, 8'h22, 1'b1, 1'b0);
        expect_idle("R8", held);
        strobe(20'hA0999, 8'h00, 1'b0, 1'b1);
        expect_idle("R8", held);
    endtask

    task automatic t_outside;
        base_sel = 1'b1; strap_up = 1'b0; ram_en = 1'b1; rotate = 1'b0; page_sel = 2'd0;
        strobe(20'hD0042, 8'h99, 1'b1, 1'b0);
        expect_write("R9", 18'h00042, 8'h99);
        strobe(20'hC0042, 8'h98, 1'b1, 1'b0);
        expect_idle("R9", 18'h00042);
        strobe(20'hE0042, 8'h00, 1'b0, 1'b1);
        expect_idle("R9", 18'h00042);
    endtask

    task automatic t_both;
        base_sel = 1'b1; strap_up = 1'b0; ram_en = 1'b1; rotate = 1'b0; page_sel = 2'd2;
        strobe(20'hD1357, 8'hA5, 1'b1, 1'b1);
        chk("R10", "host_oe stays low", 32'(host_oe), 32'd0);
        expect_write("R10", 18'h21357, 8'hA5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bases();
        t_pages();
        t_rotate();
        t_read();
        t_ram_off();
        t_outside();
        t_both();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule